// File: doc/BRIEF.md
# Sparse Column Overlap and Inhibition Engine

This block performs the overlap and inhibition stages of spatial pooling for a small bank of columns. Each column owns one permanence per input bit. A synapse is connected when its 8-bit permanence reaches a programmable threshold. The permanence code 255 stands for a weight of one and 0 for zero. For every input vector, the block counts, per column, the synapses that are both connected and driven by a set input bit. It then keeps only the strongest columns and returns an N-bit sparse vector.

Software loads permanences through a write port that addresses one column and synapse at a time. Two further write ports set the connection threshold and the minimum overlap. An input vector is handed over with a valid/ready handshake. The overlap pass spends one cycle per column. The inhibition pass then makes DESIRED_ACTIVE select-maximum sweeps over all columns. When the result is ready, the engine pulses `done` and presents `sdr_out`.

Top module: `sp_overlap_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `done` is 0 and `sdr_out` is all zeros. The connection threshold and the minimum overlap both reset to 0, and every permanence resets to 0.
- R2: Synapse j of column c is connected when its permanence (8-bit unsigned, 255 meaning one) is greater than or equal to the connection threshold. A permanence equal to the threshold counts as connected; one below it does not.
- R3: The overlap of column c is the number of synapses j for which synapse j is connected and `in_vec[j]` is 1.
- R4: A column is eligible only if its overlap is at least the minimum overlap and also at least 1.
- R5: The output sets at most DESIRED_ACTIVE bits, chosen as the eligible columns with the highest overlaps. Bit c of `sdr_out` belongs to column c.
- R6: When two eligible columns have equal overlap and cannot both win, the column with the lower index wins.
- R7: If fewer than DESIRED_ACTIVE columns are eligible, exactly the eligible columns are set. An all-zero input therefore gives an all-zero output.
- R8: An input is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 until the result appears. `done` is a one-cycle pulse that is first visible after the N+DESIRED_ACTIVE*N-th edge following the accepting edge.
- R9: Writes to permanences, to the connection threshold or to the minimum overlap are ignored while `in_ready` is 0.
- R10: `sdr_out` changes only in the cycle in which `done` is 1, and it holds its value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| perm_we | input | 1 | Permanence write strobe |
| perm_col | input | $clog2(N) | Column addressed by the write |
| perm_syn | input | $clog2(K) | Synapse addressed by the write |
| perm_data | input | PW | Permanence value (255 = one) |
| conn_thr_we | input | 1 | Connection threshold write strobe |
| conn_thr_in | input | PW | New connection threshold |
| min_ov_we | input | 1 | Minimum overlap write strobe |
| min_ov_in | input | $clog2(K+1) | New minimum overlap |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Engine idle, input can be accepted |
| in_vec | input | K | Binary input vector, bit j drives synapse j |
| done | output | 1 | One-cycle result pulse |
| sdr_out | output | N | Sparse output, one bit per column |

## Verification
The bench loads edge-placed permanences: one column sits exactly at the threshold and its neighbour one code below. A design that used a strict comparison would drop the first column, and one that compared off by one would promote the second. All columns are also given identical weights. A tie-breaker that favours higher indices, or one that selects the same column twice, then shows up as the wrong winner set. Further runs use inputs with too few eligible columns and an all-zero input. These catch a design that fills unused winner slots with ineligible or zero-overlap columns. Writes issued mid-computation, followed by a repeat of the same input, expose a store that accepts late updates. Counting edges until `done` catches a miscounted overlap or inhibition pass.

// File: rtl/sp_overlap_engine.sv
module sp_overlap_engine #(
  parameter int N  = 8,
  parameter int K  = 16,
  parameter int PW = 8,
  parameter int DESIRED_ACTIVE = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   perm_we,
  input  logic [$clog2(N)-1:0]   perm_col,
  input  logic [$clog2(K)-1:0]   perm_syn,
  input  logic [PW-1:0]          perm_data,
  input  logic                   conn_thr_we,
  input  logic [PW-1:0]          conn_thr_in,
  input  logic                   min_ov_we,
  input  logic [$clog2(K+1)-1:0] min_ov_in,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [K-1:0]           in_vec,
  output logic                   done,
  output logic [N-1:0]           sdr_out
);
  localparam int CW  = $clog2(N);
  localparam int OW  = $clog2(K+1);
  localparam int PCW = $clog2(DESIRED_ACTIVE+1);

  typedef enum logic [1:0] {S_IDLE, S_OV, S_INH} state_t;

  state_t         state;
  logic [PW-1:0]  perm [N][K];
  logic [PW-1:0]  conn_thr;
  logic [OW-1:0]  min_ov;
  logic [K-1:0]   in_q;
  logic [OW-1:0]  ov [N];
  logic [CW-1:0]  idx;
  logic [PCW-1:0] pass;
  logic [N-1:0]   win;
  logic           best_vld;
  logic [CW-1:0]  best_idx;
  logic [OW-1:0]  best_ov;

  logic           last_col;
  logic           accept;
  logic [OW-1:0]  ov_now;
  logic [N-1:0]   elig;
  logic           take;
  logic           nb_vld;
  logic [CW-1:0]  nb_idx;
  logic [OW-1:0]  nb_ov;
  logic [N-1:0]   win_next;

  assign in_ready = (state == S_IDLE);
  assign accept   = in_valid && in_ready;
  assign last_col = (idx == CW'(N-1));

  always_comb begin
    ov_now = '0;
    for (int j = 0; j < K; j++)
      ov_now = ov_now + OW'(in_q[j] && (perm[idx][j] >= conn_thr));
  end

  for (genvar c = 0; c < N; c++) begin : g_elig
    assign elig[c] = (ov[c] != '0) && (ov[c] >= min_ov);
  end

  assign take   = elig[idx] && !win[idx] && (!best_vld || ov[idx] > best_ov);
  assign nb_vld = best_vld || take;
  assign nb_idx = take ? idx : best_idx;
  assign nb_ov  = take ? ov[idx] : best_ov;

  always_comb begin
    win_next = win;
    if (last_col && nb_vld) win_next[nb_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < N; c++)
        for (int j = 0; j < K; j++)
          perm[c][j] <= '0;
      conn_thr <= '0;
      min_ov   <= '0;
    end else if (in_ready) begin
      if (perm_we)     perm[perm_col][perm_syn] <= perm_data;
      if (conn_thr_we) conn_thr <= conn_thr_in;
      if (min_ov_we)   min_ov   <= min_ov_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      in_q     <= '0;
      idx      <= '0;
      pass     <= '0;
      win      <= '0;
      best_vld <= 1'b0;
      best_idx <= '0;
      best_ov  <= '0;
      done     <= 1'b0;
      sdr_out  <= '0;
      for (int c = 0; c < N; c++) ov[c] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          in_q  <= in_vec;
          idx   <= '0;
          win   <= '0;
          state <= S_OV;
        end
        S_OV: begin
          ov[idx] <= ov_now;
          if (last_col) begin
            idx      <= '0;
            pass     <= '0;
            best_vld <= 1'b0;
            state    <= S_INH;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_INH: begin
          if (last_col) begin
            win      <= win_next;
            best_vld <= 1'b0;
            idx      <= '0;
            if (pass == PCW'(DESIRED_ACTIVE-1)) begin
              sdr_out <= win_next;
              done    <= 1'b1;
              state   <= S_IDLE;
            end else begin
              pass <= pass + 1'b1;
            end
          end else begin
            best_vld <= nb_vld;
            best_idx <= nb_idx;
            best_ov  <= nb_ov;
            idx      <= idx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5
  winner_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(sdr_out) <= DESIRED_ACTIVE));

  // R4
  winners_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((sdr_out & ~elig) == '0));

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  thr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && conn_thr_we) |=> $stable(conn_thr));

  // R10
  sdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdr_out) |-> done);
endmodule

// File: tb/sp_overlap_engine_test.sv
module sp_overlap_engine_test;
  localparam int N = 8, K = 16, PW = 8, DA = 3;
  localparam int CW = $clog2(N), SW = $clog2(K), OW = $clog2(K+1);
  localparam int LAT = N + DA*N;

  logic clk = 0, rst_n = 0;
  logic perm_we = 0, conn_thr_we = 0, min_ov_we = 0, in_valid = 0;
  logic [CW-1:0] perm_col = '0;
  logic [SW-1:0] perm_syn = '0;
  logic [PW-1:0] perm_data = '0, conn_thr_in = '0;
  logic [OW-1:0] min_ov_in = '0;
  logic [K-1:0]  in_vec = '0;
  logic in_ready, done;
  logic [N-1:0] sdr_out;

  int checks = 0, failures = 0;
  int m_perm [N][K];
  int m_thr = 0, m_min = 0;

  always #2.5 clk = ~clk;

  sp_overlap_engine #(.N(N), .K(K), .PW(PW), .DESIRED_ACTIVE(DA)) uut (
    .clk(clk), .rst_n(rst_n), .perm_we(perm_we), .perm_col(perm_col),
    .perm_syn(perm_syn), .perm_data(perm_data), .conn_thr_we(conn_thr_we),
    .conn_thr_in(conn_thr_in), .min_ov_we(min_ov_we), .min_ov_in(min_ov_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_vec(in_vec),
    .done(done), .sdr_out(sdr_out));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model(input logic [K-1:0] v);
    int ov [N];
    logic [N-1:0] w = '0;
    for (int c = 0; c < N; c++) begin
      ov[c] = 0;
      for (int j = 0; j < K; j++)
        if (v[j] && m_perm[c][j] >= m_thr) ov[c]++;
    end
    for (int p = 0; p < DA; p++) begin
      int b = -1;
      for (int c = 0; c < N; c++)
        if (!w[c] && ov[c] >= 1 && ov[c] >= m_min && (b < 0 || ov[c] > ov[b])) b = c;
      if (b >= 0) w[b] = 1'b1;
    end
    return w;
  endfunction

  task automatic wr_perm(input int c, input int s, input int d);
    @(negedge clk);
    perm_we = 1; perm_col = CW'(c); perm_syn = SW'(s); perm_data = PW'(d);
    m_perm[c][s] = d;
    @(negedge clk);
    perm_we = 0;
  endtask

  task automatic set_cfg(input int thr, input int mn);
    @(negedge clk);
    conn_thr_we = 1; conn_thr_in = PW'(thr); min_ov_we = 1; min_ov_in = OW'(mn);
    m_thr = thr; m_min = mn;
    @(negedge clk);
    conn_thr_we = 0; min_ov_we = 0;
  endtask

  task automatic run(input logic [K-1:0] v, input bit poke, output logic [N-1:0] res, output int lat);
    @(negedge clk);
    in_valid = 1; in_vec = v;
    @(negedge clk);
    in_valid = 0;
    lat = 0;
    if (poke) begin
      perm_we = 1; perm_col = '0; perm_syn = '0; perm_data = 8'hFF;
      conn_thr_we = 1; conn_thr_in = '0; min_ov_we = 1; min_ov_in = '0;
    end
    while (!done && lat < 4*LAT) begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin perm_we = 0; conn_thr_we = 0; min_ov_we = 0; end
    end
    res = sdr_out;
  endtask

  initial begin
    logic [N-1:0] r, r2;
    int lat;
    for (int c = 0; c < N; c++) for (int j = 0; j < K; j++) m_perm[c][j] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 in_ready", 64'(in_ready), 1);
    chk("R1 done", 64'(done), 0);
    chk("R1 sdr_out", 64'(sdr_out), 0);

    // R2: threshold equality; column 0 at threshold, column 1 one below
    set_cfg(100, 1);
    for (int j = 0; j < 4; j++) begin wr_perm(0, j, 100); wr_perm(1, j, 99); end
    run('1, 0, r, lat);
    chk("R2 equal counts, below does not", 64'(r), 64'h01);
    chk("R8 latency", 64'(lat), 64'(LAT));
    @(negedge clk);
    chk("R8 done single pulse", 64'(done), 0);
    repeat (4) @(negedge clk);
    chk("R10 sdr_out holds", 64'(sdr_out), 64'h01);

    // R6: identical columns tie, lowest indices win
    for (int c = 0; c < N; c++) for (int j = 0; j < K; j++) wr_perm(c, j, 200);
    set_cfg(128, 1);
    run(16'h00F0, 0, r, lat);
    chk("R6 tie to lower index", 64'(r), 64'((1 << DA) - 1));

    // R7: all-zero input
    run('0, 0, r, lat);
    chk("R7 zero input", 64'(r), 0);

    // R7: only one column eligible
    for (int j = 0; j < K; j++) wr_perm(5, j, 255);
    for (int c = 0; c < N; c++) if (c != 5) for (int j = 8; j < K; j++) wr_perm(c, j, 0);
    set_cfg(128, 12);
    run('1, 0, r, lat);
    chk("R7 fewer eligible", 64'(r), 64'h20);
    chk("R4 min overlap", 64'(r), 64'(model('1)));

    // R3 R4 R5 R6: random permanences and inputs
    for (int t = 0; t < 30; t++) begin
      logic [K-1:0] v;
      for (int c = 0; c < N; c++) for (int j = 0; j < K; j++) wr_perm(c, j, $urandom_range(0, 255));
      set_cfg($urandom_range(40, 200), $urandom_range(0, 6));
      for (int s = 0; s < 3; s++) begin
        v = K'($urandom);
        run(v, 0, r, lat);
        chk("R3 R5 random vs model", 64'(r), 64'(model(v)));
      end
    end

    // R9: writes while busy are ignored
    set_cfg(150, 2);
    wr_perm(0, 0, 10);
    run(16'hA5C3, 1, r, lat);
    chk("R9 busy writes ignored (result)", 64'(r), 64'(model(16'hA5C3)));
    run(16'hA5C3, 0, r2, lat);
    chk("R9 busy writes ignored (state kept)", 64'(r2), 64'(r));
    run(16'h0001, 0, r2, lat);
    chk("R9 perm 0,0 unchanged", 64'(r2), 64'(model(16'h0001)));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule